// File: doc/BRIEF.md
# Add/Subtract Condition Flag Unit

This unit forms the four arithmetic condition flags for a two's-complement add or subtract: negative (N), zero (Z), carry (C) and overflow (V). It looks at the two operands, the result that an adder elsewhere in the datapath has already produced, and a select that says whether the operation was an add or a subtract. It does not repeat the addition. C and V are worked out from the sign bits of the two operands and of the result alone. After a subtract, C means that no borrow occurred.

The flags are available combinationally in the same cycle. They also feed a small holding register. The N/Z pair and the C/V pair each have their own load enable, so an instruction can update one pair while the other pair keeps its value.

Top module: `arith_flag_unit`

## Requirements
- R1: When bit W-1 of `result` is 1, `n_now` is 1 and `z_now` is 0.
- R2: When `result` is all zeros, `z_now` is 1 and `n_now` is 0. For any other result with bit W-1 clear, both are 0.
- R3: When `sub_sel` is 0 (add), `c_now` is 1 exactly when any of these holds: both operands have their top bit set; `op_a` has its top bit set and the result does not; `op_b` has its top bit set and the result does not.
- R4: When `sub_sel` is 1 (subtract, A minus B), `c_now` is 1 exactly when any of these holds: `op_a` is negative and `op_b` is not; `op_a` is negative and the result is not; neither `op_b` nor the result is negative. For a result equal to A minus B, this means "no borrow".
- R5: For an add, `v_now` is 1 exactly when the operands have the same sign and the sign of the result differs from it.
- R6: For a subtract, `v_now` is 1 exactly when the operands differ in sign and the sign of the result differs from the sign of `op_a`.
- R7: While `rst_n` is low, all four held flags (`n_q`, `z_q`, `c_q`, `v_q`) are 0.
- R8: On a rising clock edge with `nz_en` high, `n_q`/`z_q` take the values `n_now`/`z_now` had before the edge. With `nz_en` low they keep their values, whatever `cv_en` does.
- R9: On a rising clock edge with `cv_en` high, `c_q`/`v_q` take the values `c_now`/`v_now` had before the edge. With `cv_en` low they keep their values, whatever `nz_en` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (subtrahend for a subtract) |
| result | input | W | Sum or difference from the datapath adder |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| nz_en | input | 1 | Load enable for held N and Z |
| cv_en | input | 1 | Load enable for held C and V |
| n_now | output | 1 | Combinational negative flag |
| z_now | output | 1 | Combinational zero flag |
| c_now | output | 1 | Combinational carry / no-borrow flag |
| v_now | output | 1 | Combinational overflow flag |
| n_q | output | 1 | Held negative flag |
| z_q | output | 1 | Held zero flag |
| c_q | output | 1 | Held carry flag |
| v_q | output | 1 | Held overflow flag |

## Verification
The combinational flags are compared against a 33-bit reference add and subtract. The operands used are the signed extremes 0x7FFFFFFF and 0x80000000, zero, all-ones, equal operands and random words. Together these separate a genuine carry out from signed overflow, and borrow from no-borrow. One directed case feeds in a result that does not match the operands, which shows that C and V follow the sign rules and not a recomputed sum. The holding register is driven through sequences that load one flag pair while the other pair is disabled, so a swapped or shared enable leaves a wrong value behind.

// File: rtl/arith_flag_unit.sv
module arith_flag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] result,
  input  logic         sub_sel,
  input  logic         nz_en,
  input  logic         cv_en,
  output logic         n_now,
  output logic         z_now,
  output logic         c_now,
  output logic         v_now,
  output logic         n_q,
  output logic         z_q,
  output logic         c_q,
  output logic         v_q
);
  localparam int MSB = W - 1;

  logic sa, sb, sr;
  logic add_c, add_v, sub_c, sub_v;

  assign sa = op_a[MSB];
  assign sb = op_b[MSB];
  assign sr = result[MSB];

  assign n_now = sr;
  assign z_now = (result == '0);

  assign add_c = (sa & sb) | (sa & ~sr) | (sb & ~sr);
  assign sub_c = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
  assign add_v = (sa == sb) & (sr != sa);
  assign sub_v = (sa != sb) & (sr != sa);

  assign c_now = sub_sel ? sub_c : add_c;
  assign v_now = sub_sel ? sub_v : add_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else if (nz_en) begin
      n_q <= n_now;
      z_q <= z_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      v_q <= 1'b0;
    end else if (cv_en) begin
      c_q <= c_now;
      v_q <= v_now;
    end
  end
endmodule

// File: rtl/arith_flag_unit_chk.sv
module arith_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] result,
  input logic         sub_sel,
  input logic         nz_en,
  input logic         cv_en,
  input logic         n_now,
  input logic         z_now,
  input logic         c_now,
  input logic         v_now,
  input logic         n_q,
  input logic         z_q,
  input logic         c_q,
  input logic         v_q
);
  // R1
  neg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result[W-1] |-> (n_now && !z_now));

  // R2
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result == '0) |-> (z_now && !n_now));

  // R3
  add_both_neg_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_sel && op_a[W-1] && op_b[W-1]) |-> c_now);

  // R4
  sub_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_sel && op_a[W-1] && !op_b[W-1]) |-> c_now);

  // R5
  add_same_sign_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_sel && (op_a[W-1] == op_b[W-1]) && (result[W-1] != op_a[W-1])) |-> v_now);

  // R6
  sub_same_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_sel && (op_a[W-1] == op_b[W-1])) |-> !v_now);

  // R8
  nz_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nz_en |=> (n_q == $past(n_now)) && (z_q == $past(z_now)));

  // R8
  nz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nz_en |=> $stable(n_q) && $stable(z_q));

  // R9
  cv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_en |=> (c_q == $past(c_now)) && (v_q == $past(v_now)));

  // R9
  cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cv_en |=> $stable(c_q) && $stable(v_q));
endmodule

bind arith_flag_unit arith_flag_unit_chk #(.W(W)) chk_i (.*);

// File: tb/arith_flag_unit_test.sv
`timescale 1ns/1ps
module arith_flag_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, result = '0;
  logic         sub_sel = 1'b0, nz_en = 1'b0, cv_en = 1'b0;
  logic         n_now, z_now, c_now, v_now, n_q, z_q, c_q, v_q;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  arith_flag_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .result(result),
    .sub_sel(sub_sel), .nz_en(nz_en), .cv_en(cv_en),
    .n_now(n_now), .z_now(z_now), .c_now(c_now), .v_now(v_now),
    .n_q(n_q), .z_q(z_q), .c_q(c_q), .v_q(v_q)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: NZCV actual %b expected %b", req, act, exp);
    end
  endtask

  // Reference: true 33-bit add or subtract; flags from the wide result.
  task automatic try_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub, input string req);
    logic [W:0] wide;
    logic [W-1:0] r;
    logic en, ez, ec, ev;
    wide = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    r  = wide[W-1:0];
    en = r[W-1];
    ez = (r == '0);
    ec = sub ? ~wide[W] : wide[W];
    ev = sub ? ((a[W-1] != b[W-1]) && (r[W-1] != a[W-1]))
             : ((a[W-1] == b[W-1]) && (r[W-1] != a[W-1]));
    @(negedge clk);
    op_a = a; op_b = b; result = r; sub_sel = sub;
    #1;
    check(req, {n_now, z_now, c_now, v_now}, {en, ez, ec, ev});
  endtask

  task automatic test_reset();
    check("R7 reset", {n_q, z_q, c_q, v_q}, 4'b0000);
  endtask

  task automatic test_add_bounds();
    try_op(32'h7FFFFFFF, 32'h00000001, 1'b0, "R1 R5 add max+1");
    try_op(32'hFFFFFFFF, 32'h00000001, 1'b0, "R2 R3 add wrap to zero");
    try_op(32'h80000000, 32'h80000000, 1'b0, "R3 R5 add min+min");
    try_op(32'h00000000, 32'h00000000, 1'b0, "R2 add zero");
    try_op(32'h80000000, 32'h7FFFFFFF, 1'b0, "R1 R3 add min+max");
    try_op(32'h00001234, 32'h00004321, 1'b0, "R2 R3 add small positive");
  endtask

  task automatic test_sub_bounds();
    try_op(32'h00000005, 32'h00000005, 1'b1, "R2 R4 sub equal");
    try_op(32'h00000000, 32'h00000001, 1'b1, "R1 R4 sub borrow");
    try_op(32'h80000000, 32'h00000001, 1'b1, "R4 R6 sub min-1");
    try_op(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, "R1 R6 sub max-(-1)");
    try_op(32'h80000000, 32'h7FFFFFFF, 1'b1, "R4 R6 sub min-max");
    try_op(32'hFFFFFFFF, 32'h80000000, 1'b1, "R4 sub -1-min");
  endtask

  task automatic test_random();
    for (int i = 0; i < 60; i++) begin
      try_op($urandom, $urandom, 1'b0, "R3 R5 random add");
      try_op($urandom, $urandom, 1'b1, "R4 R6 random sub");
    end
  endtask

  // Result not consistent with operands: flags follow sign rules only.
  task automatic test_sign_only();
    @(negedge clk);
    op_a = '0; op_b = '0; result = 32'h80000000; sub_sel = 1'b0;
    #1;
    check("R3 R5 sign-only add", {n_now, z_now, c_now, v_now}, 4'b1001);
    @(negedge clk);
    op_a = 32'h80000000; op_b = 32'h00000000; result = 32'h00000000; sub_sel = 1'b1;
    #1;
    check("R4 R6 sign-only sub", {n_now, z_now, c_now, v_now}, 4'b0111);
  endtask

  task automatic test_hold();
    @(negedge clk);
    op_a = 32'h7FFFFFFF; op_b = 32'h1; result = 32'h80000000; sub_sel = 1'b0;
    nz_en = 1'b1; cv_en = 1'b1;
    @(negedge clk);
    check("R8 R9 load both", {n_q, z_q, c_q, v_q}, 4'b1001);
    op_a = 32'hFFFFFFFF; op_b = 32'h1; result = 32'h0;
    nz_en = 1'b1; cv_en = 1'b0;
    @(negedge clk);
    check("R8 R9 load NZ only", {n_q, z_q, c_q, v_q}, 4'b0101);
    op_a = 32'h80000000; op_b = 32'h80000000; result = 32'h0;
    nz_en = 1'b0; cv_en = 1'b1;
    @(negedge clk);
    check("R9 R8 load CV only", {n_q, z_q, c_q, v_q}, 4'b0111);
    op_a = 32'h7FFFFFFF; op_b = 32'h1; result = 32'h80000000;
    nz_en = 1'b0; cv_en = 1'b0;
    @(negedge clk);
    check("R8 R9 hold both", {n_q, z_q, c_q, v_q}, 4'b0111);
    @(negedge clk);
    check("R8 R9 hold again", {n_q, z_q, c_q, v_q}, 4'b0111);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_add_bounds();
    test_sub_bounds();
    test_sign_only();
    test_random();
    test_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule